// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every destination address offered by the receive path, whether the frame is kept. It compares the 48-bit address against a small set of exact-match station slots and, for group addresses, looks up one bin of a 64-bin hash table. The all-ones address is always kept. Every decision comes with a code that says what caused the match.

A configuration port writes the slot words and the hash table. Each slot is turned off when its low word is written and turned back on when its high word is written. Software therefore loads a slot low word first, then high word, and the slot stays off between the two writes. The receive side presents an address with a strobe. One clock later the block returns a decision strobe, an accept flag and the match code.

Address byte 0 is the first byte received and sits in `da_addr[7:0]`. Bit 0 of the address is the least significant bit of byte 0. A slot's low word holds bytes 0 to 3 (`da_addr[31:0]`). Its high word holds bytes 4 and 5 (`da_addr[47:32]`).

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every slot is off and all 64 hash bins are zero. `dec_valid` is low. A non-broadcast address is rejected with code 0.
- R2: A write to a slot's low word turns that slot off. The slot then matches nothing until its high word is written.
- R3: A write to a slot's high word turns the slot on. It then matches only an address whose 48 bits equal its stored high word above its stored low word.
- R4: A unicast address (bit 0 clear) is accepted only when it equals an enabled slot. Slot s reports code s+1. Any other unicast address is rejected with code 0.
- R5: When several enabled slots hold the offered address, the lowest-numbered slot supplies the code.
- R6: The hash bin index is 6 bits. Index bit i is the XOR of address bits i, i+6, i+12, i+18, i+24, i+30, i+36 and i+42.
- R7: Bin k is bit (k mod 32) of the hash low word for k below 32, and of the hash high word otherwise. A group address that matches no slot and falls in a set bin is accepted with code 5.
- R8: An address is a group address when bit 0 is set. Only group addresses consult the hash table; a unicast address is rejected even when all bins are set. A slot match takes precedence over a hash hit.
- R9: With both hash words zero, every group address that matches no slot and is not broadcast is rejected.
- R10: The all-ones address is always accepted with code 6, whatever the slot and hash contents.
- R11: `dec_valid`, `dec_accept` and `dec_code` are registered. They describe the address offered in the previous cycle. `dec_valid` is high for exactly one cycle per offered address, and back-to-back addresses are decided in back-to-back cycles.
- R12: Configuration addresses are as follows. Address 2s writes slot s low word and 2s+1 writes slot s high word (data bits 15:0), for s = 0..3. Address 8 writes the hash low word and 9 the hash high word. Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision strobe, one cycle after `da_valid` |
| dec_accept | output | 1 | Frame is kept |
| dec_code | output | 3 | 0 none, 1-4 slot 0-3, 5 hash, 6 broadcast |

## Verification
The hash path is swept exhaustively. For each of the 64 bins set on its own, group addresses are built whose folded index covers every one of the 64 values. This separates a wrong fold, a wrong half-word split and a wrong bit position within a half. The slot path is exercised three ways:
- A single-bit flip of a stored address at each of the 48 positions, which exposes byte-order and partial-compare faults.
- Low-only, low-then-high and low-again write sequences, which distinguish the turn-on and turn-off order.
- Duplicate contents in several slots, which shows the priority order.

Further cases cover unicast addresses against a fully set table, broadcast, writes to unused addresses, and back-to-back address strobes.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    localparam int ADDR_W  = 48;
    localparam int WORD_W  = 32;
    localparam int HI_W    = ADDR_W - WORD_W;
    localparam int BIN_W   = 6;
    localparam int FOLDS   = ADDR_W / BIN_W;

    // XOR-fold of the 48 address bits into a bin index.
    function automatic logic [BIN_W-1:0] fold_bin(input logic [ADDR_W-1:0] a);
        logic [BIN_W-1:0] r;
        r = '0;
        for (int j = 0; j < FOLDS; j++) begin
            r = r ^ a[j*BIN_W +: BIN_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/addr_slot.sv
module addr_slot
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] lo_data,
    input  logic [HI_W-1:0]   hi_data,
    input  logic [ADDR_W-1:0] cand,
    output logic              hit
);

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [WORD_W-1:0] lo;
        logic              armed;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.lo    = lo_data;
            st_d.armed = 1'b0;
        end
        if (wr_hi) begin
            st_d.hi    = hi_data;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.armed && (cand == {st_q.hi, st_q.lo});

    // R2
    slot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> !hit);

    // R3
    slot_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (hit == (cand == {$past(hi_data), st_q.lo})));

endmodule

// File: rtl/hash_bins.sv
module hash_bins
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BIN_W-1:0]  idx,
    output logic              hit
);

    localparam int BINS = 1 << BIN_W;
    localparam int HALF = BINS / 2;

    logic [BINS-1:0] bins_d, bins_q;

    always_comb begin
        bins_d = bins_q;
        if (wr_lo) bins_d[HALF-1:0]    = wdata[HALF-1:0];
        if (wr_hi) bins_d[BINS-1:HALF] = wdata[HALF-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bins_q <= '0;
        else        bins_q <= bins_d;
    end

    assign hit = bins_q[idx];

    // R7
    bin_low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (idx[BIN_W-1] || (hit == (($past(wdata) >> idx[BIN_W-2:0]) & 32'd1) != 32'd0)));

    // R7
    bin_high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (!idx[BIN_W-1] || (hit == (($past(wdata) >> idx[BIN_W-2:0]) & 32'd1) != 32'd0)));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import addr_filt_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int CODE_W    = $clog2(NUM_SLOTS + 3),
    localparam int CFG_AW    = $clog2(2 * NUM_SLOTS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [CODE_W-1:0] dec_code
);

    localparam logic [CODE_W-1:0] CODE_NONE  = '0;
    localparam logic [CODE_W-1:0] CODE_HASH  = CODE_W'(NUM_SLOTS + 1);
    localparam logic [CODE_W-1:0] CODE_BCAST = CODE_W'(NUM_SLOTS + 2);
    localparam int HASH_LO_A = 2 * NUM_SLOTS;
    localparam int HASH_HI_A = 2 * NUM_SLOTS + 1;

    typedef struct packed {
        logic              vld;
        logic              acc;
        logic [CODE_W-1:0] code;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 hash_hit;
    logic [BIN_W-1:0]     bin_idx;
    logic                 is_bcast;
    logic                 is_group;
    logic [CODE_W-1:0]    slot_code;

    assign bin_idx  = fold_bin(da_addr);
    assign is_bcast = &da_addr;
    assign is_group = da_addr[0];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        addr_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (cfg_we && (cfg_addr == CFG_AW'(2 * s))),
            .wr_hi   (cfg_we && (cfg_addr == CFG_AW'(2 * s + 1))),
            .lo_data (cfg_wdata),
            .hi_data (cfg_wdata[HI_W-1:0]),
            .cand    (da_addr),
            .hit     (slot_hit[s])
        );
    end

    hash_bins u_hash (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (cfg_we && (cfg_addr == CFG_AW'(HASH_LO_A))),
        .wr_hi (cfg_we && (cfg_addr == CFG_AW'(HASH_HI_A))),
        .wdata (cfg_wdata),
        .idx   (bin_idx),
        .hit   (hash_hit)
    );

    always_comb begin
        slot_code = CODE_NONE;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s]) slot_code = CODE_W'(s + 1);
        end
    end

    always_comb begin
        dec_d      = '0;
        dec_d.vld  = da_valid;
        if (da_valid) begin
            if (is_bcast)                  dec_d.code = CODE_BCAST;
            else if (slot_code != CODE_NONE) dec_d.code = slot_code;
            else if (is_group && hash_hit) dec_d.code = CODE_HASH;
            else                           dec_d.code = CODE_NONE;
            dec_d.acc = (dec_d.code != CODE_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.vld;
    assign dec_accept = dec_q.acc;
    assign dec_code   = dec_q.code;

    // R11
    dec_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> dec_valid);

    // R11
    dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !dec_valid && !dec_accept);

    // R10
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && is_bcast) |=> (dec_accept && dec_code == CODE_BCAST));

    // R4
    unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !is_group && slot_hit == '0) |=> !dec_accept);

    // R9
    group_miss_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && is_group && !is_bcast && !hash_hit && slot_hit == '0) |=> !dec_accept);

    // R5
    slot_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !is_bcast && slot_hit[0]) |=> (dec_code == CODE_W'(1)));

endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [2:0] C_NONE = 3'd0;
    localparam logic [2:0] C_HASH = 3'd5;
    localparam logic [2:0] C_BC   = 3'd6;

    always #5 clk = ~clk;

    rx_addr_filter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .da_valid   (da_valid),
        .da_addr    (da_addr),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_code   (dec_code)
    );

    function automatic logic [5:0] ref_bin(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int b = 0; b < 48; b++) r[b % 6] = r[b % 6] ^ a[b];
        return r;
    endfunction

    function automatic logic [47:0] group_for_bin(input logic [5:0] m);
        logic [47:0] a = 48'h6A_C3_91_7E_24_01;
        logic [5:0]  f = ref_bin(a);
        a[11:6] = a[11:6] ^ (f ^ m);
        return a;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_dec(input logic [47:0] a, input logic exp_acc,
                              input logic [2:0] exp_code, input string req);
        @(negedge clk);
        da_valid = 1'b1; da_addr = a;
        @(negedge clk);
        da_valid = 1'b0;
        n_chk++;
        if (dec_valid !== 1'b1 || dec_accept !== exp_acc || dec_code !== exp_code) begin
            n_fail++;
            $display("FAIL %s addr=%h: vld/acc/code=%b/%b/%0d expected 1/%b/%0d",
                     req, a, dec_valid, dec_accept, dec_code, exp_acc, exp_code);
        end
    endtask

    task automatic expect_idle(input string req);
        n_chk++;
        if (dec_valid !== 1'b0 || dec_accept !== 1'b0) begin
            n_fail++;
            $display("FAIL %s idle: vld/acc=%b/%b expected 0/0", req, dec_valid, dec_accept);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [47:0] a0, a1, b, m, u;
        a0 = 48'h0B0A_0908_0706;
        a1 = 48'h0000_1234_5670;
        b  = 48'h00AA_BBCC_DD00;
        m  = 48'h0000_5E00_0001;
        u  = 48'h1111_2222_3340;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1");
        expect_dec(a0, 1'b0, C_NONE, "R1");
        expect_dec(48'h0, 1'b0, C_NONE, "R1");
        expect_dec(m, 1'b0, C_NONE, "R9");

        // R10: broadcast with empty configuration
        expect_dec({48{1'b1}}, 1'b1, C_BC, "R10");

        // R3: slot 0 loaded low then high
        wr(4'd0, a0[31:0]);
        wr(4'd1, {16'h0, a0[47:32]});
        expect_dec(a0, 1'b1, 3'd1, "R3");
        // R4: every single-bit neighbour is rejected
        for (int i = 0; i < 48; i++) begin
            expect_dec(a0 ^ (48'd1 << i), 1'b0, C_NONE, "R4");
        end

        // R2: low-only write leaves slot 1 off
        wr(4'd2, a1[31:0]);
        expect_dec(a1, 1'b0, C_NONE, "R2");
        wr(4'd3, 32'h0);
        expect_dec(a1, 1'b1, 3'd2, "R3");
        wr(4'd2, a1[31:0]);
        expect_dec(a1, 1'b0, C_NONE, "R2");
        wr(4'd3, 32'hFFFF_0000);
        expect_dec(a1, 1'b1, 3'd2, "R3");

        // R5: priority across duplicate slots
        wr(4'd6, b[31:0]);
        wr(4'd7, {16'h0, b[47:32]});
        expect_dec(b, 1'b1, 3'd4, "R5");
        wr(4'd4, b[31:0]);
        wr(4'd5, {16'h0, b[47:32]});
        expect_dec(b, 1'b1, 3'd3, "R5");
        wr(4'd0, b[31:0]);
        wr(4'd1, {16'h0, b[47:32]});
        expect_dec(b, 1'b1, 3'd1, "R5");

        // R8: group address held in a slot wins over the hash table
        wr(4'd6, m[31:0]);
        wr(4'd7, {16'h0, m[47:32]});
        expect_dec(m, 1'b1, 3'd4, "R8");
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        expect_dec(m, 1'b1, 3'd4, "R8");
        expect_dec(u, 1'b0, C_NONE, "R8");
        expect_dec(group_for_bin(6'd17), 1'b1, C_HASH, "R8");
        // R10: broadcast still wins with everything set
        expect_dec({48{1'b1}}, 1'b1, C_BC, "R10");

        // R6/R7: exhaustive bin sweep
        for (int k = 0; k < 64; k++) begin
            logic [63:0] tbl;
            tbl = 64'd1 << k;
            wr(4'd8, tbl[31:0]);
            wr(4'd9, tbl[63:32]);
            for (int mm = 0; mm < 64; mm++) begin
                expect_dec(group_for_bin(6'(mm)), (mm == k), (mm == k) ? C_HASH : C_NONE,
                           (k < 32) ? "R6/R7 low half" : "R6/R7 high half");
            end
        end

        // R9: cleared table rejects group misses
        wr(4'd8, 32'h0);
        wr(4'd9, 32'h0);
        for (int mm = 0; mm < 64; mm += 9) begin
            expect_dec(group_for_bin(6'(mm)), 1'b0, C_NONE, "R9");
        end

        // R12: unused addresses change nothing
        for (int x = 10; x < 16; x++) wr(4'(x), 32'hFFFF_FFFF);
        expect_dec(group_for_bin(6'd40), 1'b0, C_NONE, "R12");
        expect_dec(b, 1'b1, 3'd1, "R12");
        expect_dec(a1, 1'b1, 3'd2, "R12");
        expect_dec(m, 1'b1, 3'd4, "R12");

        // R11: back-to-back strobes, then idle
        @(negedge clk);
        da_valid = 1'b1; da_addr = b;
        @(negedge clk);
        da_addr = u;
        n_chk++;
        if (dec_valid !== 1'b1 || dec_accept !== 1'b1 || dec_code !== 3'd1) begin
            n_fail++;
            $display("FAIL R11 first: vld/acc/code=%b/%b/%0d expected 1/1/1",
                     dec_valid, dec_accept, dec_code);
        end
        @(negedge clk);
        da_valid = 1'b0;
        n_chk++;
        if (dec_valid !== 1'b1 || dec_accept !== 1'b0 || dec_code !== C_NONE) begin
            n_fail++;
            $display("FAIL R11 second: vld/acc/code=%b/%b/%0d expected 1/0/0",
                     dec_valid, dec_accept, dec_code);
        end
        @(negedge clk);
        expect_idle("R11");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule